// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned binary operands and a single forced carry bit. It returns the sum and an overflow carry that leaves the top stage. It is purely combinational: no clock, no reset and no pipeline registers. The result follows the inputs after the logic has settled.

Each bit position produces a generate term (both operand bits set) and a propagate term (operand bits differ). The stages are cut into groups of three. Inside a group, every carry is computed from the generate and propagate terms and the group's incoming carry by a flattened sum of products, with no ripple between bits. The incoming carry of each group is the top carry of the group below it. The lowest group takes the forced carry.

The operand width is a parameter and must be a multiple of three. The default of 30 bits gives ten groups. Against a plain ripple adder, this arrangement trades a modest amount of extra lookahead logic for a carry path that crosses one group per step instead of one bit per step.

Top module: `gcla_adder`

## Requirements
- R1: For any operands and forced carry, `sum` equals the low WIDTH bits of `opA + opB + forceCarry`, all treated as unsigned.
- R2: `carryOut` equals bit WIDTH of the full unsigned total `opA + opB + forceCarry`.
- R3: `forceCarry` enters at bit 0 with weight one. With both operands zero, `forceCarry = 1` gives `sum = 1` and `carryOut = 0`.
- R4: With both operands zero and `forceCarry = 0`, `sum` is all zeros and `carryOut` is 0.
- R5: When every bit position propagates (`opB` is the bitwise complement of `opA`), `forceCarry` travels the full width. With `forceCarry = 1`, `sum` is all zeros and `carryOut` is 1. With `forceCarry = 0`, `sum` is all ones and `carryOut` is 0.
- R6: A group whose three bits all propagate passes its incoming carry unchanged to its top carry.
- R7: A group whose top bit generates (both operand bits set) produces a top carry of 1 whatever the bits below it hold.
- R8: A group whose top bit kills (both operand bits clear) produces a top carry of 0 whatever the bits below it hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| forceCarry | input | 1 | Carry forced into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carryOut | output | 1 | Carry out of the top stage |

## Verification
The bench targets the long carry chain. When one operand is the complement of the other, the forced carry must cross all ten groups. A design that drops the group carry between groups, or reads it from the wrong bit, returns a sum with stray ones or zeros at a group boundary and the wrong overflow carry.

Single groups are also driven to generate or kill at their top bit. A wrong product term in the flattened lookahead then shows up as a carry appearing or vanishing in the next group.

All-ones operands, zero operands with the forced carry alone, and a few hundred random vectors check the full total. These catch a dropped or misplaced forced carry and a wrong overflow bit.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  localparam int GROUP_W = 3;

  // per-group strobes handed from the bit datapath to the lookahead logic
  typedef struct packed {
    logic [GROUP_W-1:0] gen;
    logic [GROUP_W-1:0] prop;
  } grpPg_t;
endpackage

// File: rtl/gcla_bit_datapath.sv
module gcla_bit_datapath #(
  parameter int WIDTH = 30
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] carryIn,
  output logic [WIDTH-1:0] genBits,
  output logic [WIDTH-1:0] propBits,
  output logic [WIDTH-1:0] sum
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign genBits[i]  = opA[i] & opB[i];
      assign propBits[i] = opA[i] ^ opB[i];
      assign sum[i]      = propBits[i] ^ carryIn[i];
    end
  endgenerate
endmodule

// File: rtl/gcla_group_lookahead.sv
module gcla_group_lookahead
  import gcla_pkg::*;
(
  input  grpPg_t               pg,
  input  logic                 grpCarryIn,
  output logic [GROUP_W-1:0]   bitCarryOut
);
  // flattened carry for bit j: gen[j] | prop[j]gen[j-1] | ... | prop[j..0]cin
  function automatic logic flatCarry(input grpPg_t s, input logic cin, input int j);
    logic acc;
    logic chain;
    acc   = 1'b0;
    chain = 1'b1;
    for (int k = GROUP_W - 1; k >= 0; k--) begin
      if (k <= j) begin
        acc   = acc | (chain & s.gen[k]);
        chain = chain & s.prop[k];
      end
    end
    return acc | (chain & cin);
  endfunction

  always_comb begin
    for (int j = 0; j < GROUP_W; j++) begin
      bitCarryOut[j] = flatCarry(pg, grpCarryIn, j);
    end
  end

  logic topCarry;
  assign topCarry = bitCarryOut[GROUP_W-1];

  always_comb begin
    if (&pg.prop) AST_FULL_PROPAGATE: assert (topCarry == grpCarryIn); // R6
    if (pg.gen[GROUP_W-1]) AST_TOP_GENERATE: assert (topCarry); // R7
    if (!pg.gen[GROUP_W-1] && !pg.prop[GROUP_W-1]) AST_TOP_KILL: assert (!topCarry); // R8
  end
endmodule

// File: rtl/gcla_carry_chain.sv
module gcla_carry_chain
  import gcla_pkg::*;
#(
  parameter int WIDTH = 30
) (
  input  logic [WIDTH-1:0] genBits,
  input  logic [WIDTH-1:0] propBits,
  input  logic             forceCarry,
  output logic [WIDTH-1:0] carryIn,
  output logic             carryOut
);
  localparam int NGROUPS = WIDTH / GROUP_W;

  logic [NGROUPS:0]  grpCarry;
  logic [WIDTH-1:0]  bitCarryOut;

  assign grpCarry[0] = forceCarry;

  genvar g;
  generate
    for (g = 0; g < NGROUPS; g++) begin : g_grp
      grpPg_t pg;
      assign pg.gen  = genBits[g*GROUP_W +: GROUP_W];
      assign pg.prop = propBits[g*GROUP_W +: GROUP_W];

      gcla_group_lookahead u_look (
        .pg          (pg),
        .grpCarryIn  (grpCarry[g]),
        .bitCarryOut (bitCarryOut[g*GROUP_W +: GROUP_W])
      );

      // group carries ripple from group to group
      assign grpCarry[g+1] = bitCarryOut[g*GROUP_W + GROUP_W - 1];
    end
  endgenerate

  assign carryIn  = {bitCarryOut[WIDTH-2:0], forceCarry};
  assign carryOut = grpCarry[NGROUPS];

  always_comb begin
    if (&propBits) AST_CHAIN_PASS: assert (carryOut == forceCarry); // R5
  end
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder #(
  parameter int WIDTH = 30
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             forceCarry,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH-1:0] genBits;
  logic [WIDTH-1:0] propBits;
  logic [WIDTH-1:0] carryIn;

  gcla_bit_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .genBits  (genBits),
    .propBits (propBits),
    .sum      (sum)
  );

  gcla_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .genBits    (genBits),
    .propBits   (propBits),
    .forceCarry (forceCarry),
    .carryIn    (carryIn),
    .carryOut   (carryOut)
  );

  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, forceCarry};

  always_comb begin
    AST_SUM_MATCH: assert (sum == refTotal[WIDTH-1:0]); // R1
    AST_OVERFLOW_CARRY: assert (carryOut == refTotal[WIDTH]); // R2
  end
endmodule

// File: tb/gcla_adder_test.sv
module gcla_adder_test;
  localparam int W = 30;
  localparam int NG = W / 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         forceCarry = 1'b0;
  logic [W-1:0] sum;
  logic         carryOut;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  gcla_adder #(.WIDTH(W)) uut (
    .opA(opA), .opB(opB), .forceCarry(forceCarry),
    .sum(sum), .carryOut(carryOut)
  );

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic cf, input string req);
    logic [W:0] expTotal;
    @(posedge clk);
    opA = a; opB = b; forceCarry = cf;
    expTotal = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cf};
    @(negedge clk);
    vectors++;
    if (sum !== expTotal[W-1:0] || carryOut !== expTotal[W]) begin
      misses++;
      $display("FAIL %s: a=%h b=%h cf=%b got sum=%h cout=%b expected sum=%h cout=%b",
               req, a, b, cf, sum, carryOut, expTotal[W-1:0], expTotal[W]);
    end
  endtask

  task automatic testIdle();
    @(negedge clk);
    vectors++;
    if (sum !== '0 || carryOut !== 1'b0) begin
      misses++;
      $display("FAIL R4 idle: got sum=%h cout=%b expected sum=0 cout=0", sum, carryOut);
    end
    applyCheck('0, '0, 1'b0, "R4 zeros");
  endtask

  task automatic testForcedCarry();
    applyCheck('0, '0, 1'b1, "R3 forced carry alone");
    applyCheck('1, '0, 1'b1, "R3 forced carry into all ones");
  endtask

  task automatic testAllOnes();
    applyCheck('1, '0, 1'b0, "R1 all ones plus zero");
    applyCheck('1, '1, 1'b0, "R2 all ones twice");
    applyCheck('1, '1, 1'b1, "R2 all ones twice plus carry");
  endtask

  task automatic testPropagateChain();
    logic [W-1:0] alt;
    alt = {(W/2){2'b10}};
    applyCheck(alt, ~alt, 1'b1, "R5 full chain carry in");
    applyCheck(alt, ~alt, 1'b0, "R5 full chain no carry");
    applyCheck(~alt, alt, 1'b1, "R5 full chain swapped");
  endtask

  task automatic testGroups();
    for (int g = 0; g < NG; g++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      // R6: group g all propagate, carry from group below generated at its top
      a = '0; b = '0;
      a[g*3 +: 3] = 3'b101; b[g*3 +: 3] = 3'b010;
      if (g > 0) begin a[g*3-1] = 1'b1; b[g*3-1] = 1'b1; end
      applyCheck(a, b, (g == 0), "R6 group pass through");
      // R7: top bit generates, lower bits kill
      a = '0; b = '0;
      a[g*3+2] = 1'b1; b[g*3+2] = 1'b1;
      applyCheck(a, b, 1'b1, "R7 top generate");
      // R8: top bit kills, lower bits generate
      a = '0; b = '0;
      a[g*3 +: 2] = 2'b11; b[g*3 +: 2] = 2'b11;
      applyCheck(a, b, 1'b1, "R8 top kill");
    end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 300; n++) begin
      applyCheck(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    end
  endtask

  initial begin
    testIdle();
    testForcedCarry();
    testAllOnes();
    testPropagateChain();
    testGroups();
    testRandom();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule